// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block steers a DMA engine through a chain of descriptors kept in host memory. Software first loads the table base address and then the control word, which holds the descriptor count and three global enables. A non-zero count starts a run. The sequencer then fetches the descriptors one at a time. For each descriptor with a non-zero length it sends a transfer command to the datapath and waits for that datapath to report completion.

After each descriptor finishes, the sequencer records its index. Under a selectable policy it can also emit a write-back of that index, and after the final descriptor it can raise a message interrupt. Each descriptor carries its own write-back and interrupt bits, and these are ORed with the global enables. A cycle counter measures how long the run lasts, and a status word shows the last completed index and a busy flag.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, busy is 0, the status word reads 0x0000FFFF, the performance counter reads 0, and fetch_req, xfer_req, wb_req and irq are all 0.
- R2: Control word (register 0) layout: bits [15:0] are the descriptor count, bit 16 is the global interrupt enable, bit 17 is the global write-back enable, and bit 18 selects write-back after every descriptor. Writing it while idle with a non-zero count sets busy on the next cycle. A count of zero does not start a run.
- R3: The table base is register 1, and its low four bits always read as zero. Descriptor i is fetched at base + 16*i. Fetches go in index order, each fetch_req lasts one cycle, and at most one fetch is outstanding at a time.
- R4: Descriptor word 0 layout: bits [15:0] are the length in dwords, bit 16 is the descriptor write-back enable, and bit 17 is the descriptor interrupt enable. Word 1 is the transfer address. A transfer command carries the fetched length and address.
- R5: A descriptor with length zero completes without any transfer command.
- R6: When descriptor i completes, wb_req pulses with wb_idx = i if both of these hold: the global or descriptor write-back enable is set, and i is the first descriptor, the last descriptor, or every-descriptor mode is selected.
- R7: Status (register 2) holds the last completed descriptor index in bits [15:0] and busy in bit 16.
- R8: irq pulses exactly once per run, in the completion cycle of the last descriptor, if the global interrupt enable or that descriptor's interrupt bit is set. busy falls on the next cycle.
- R9: The performance counter (register 3) is cleared when a run starts. It then counts each cycle in which busy is 1, and holds its value after the run ends.
- R10: Writes to register 0 or register 1 while busy have no effect on the running chain or on their read-back values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_req | output | 1 | Descriptor fetch request, one cycle |
| fetch_addr | output | 32 | Descriptor address |
| fetch_vld | input | 1 | Descriptor response valid |
| fetch_word0 | input | 18 | Descriptor word 0 fields |
| fetch_word1 | input | 32 | Descriptor transfer address |
| xfer_req | output | 1 | Transfer command, one cycle |
| xfer_len | output | 16 | Transfer length in dwords |
| xfer_addr | output | 32 | Transfer address |
| xfer_done | input | 1 | Transfer completion |
| wb_req | output | 1 | Last-completed write-back request |
| wb_idx | output | 16 | Index written back |
| irq | output | 1 | Message interrupt request |
| busy | output | 1 | Run in progress |

## Verification
The assertions assume the following about the environment:
- fetch_vld arrives only while a fetch is outstanding, and no earlier than one cycle after the request.
- xfer_done arrives only after a transfer command.
- Each request gets exactly one response.

The bench respects these assumptions with a responder that counts down a latency of one to three cycles from each request and returns one pulse per request. It then sweeps descriptor counts 1 to 5 against all eight combinations of global enables, with zero and non-zero lengths and varied per-descriptor bits.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 16,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [1:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_vld,
  input  logic [LW+1:0] fetch_word0,
  input  logic [AW-1:0] fetch_word1,
  output logic          xfer_req,
  output logic [LW-1:0] xfer_len,
  output logic [AW-1:0] xfer_addr,
  input  logic          xfer_done,
  output logic          wb_req,
  output logic [CW-1:0] wb_idx,
  output logic          irq,
  output logic          busy
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_XFER, S_XWAIT, S_DONE} st_t;
  st_t st;

  logic [31:0]   ctrl_q;
  logic [AW-1:0] base_q, daddr_q;
  logic [CW-1:0] idx_q, last_q;
  logic [LW-1:0] len_q;
  logic          d_wb_q, d_irq_q;
  logic [PW-1:0] perf_q;

  wire [CW-1:0] cnt     = ctrl_q[CW-1:0];
  wire          g_irq   = ctrl_q[CW];
  wire          g_wb    = ctrl_q[CW+1];
  wire          g_all   = ctrl_q[CW+2];
  wire          idle    = (st == S_IDLE);
  wire          start   = reg_wr && reg_waddr == 2'd0 && idle && reg_wdata[CW-1:0] != '0;
  wire          is_last = (idx_q == cnt - CW'(1));

  assign busy       = !idle;
  assign fetch_req  = (st == S_FETCH);
  assign fetch_addr = base_q + (AW'(idx_q) << 4);
  assign xfer_req   = (st == S_XFER);
  assign xfer_len   = len_q;
  assign xfer_addr  = daddr_q;
  assign wb_req     = (st == S_DONE) && (g_wb || d_wb_q) && (g_all || idx_q == '0 || is_last);
  assign wb_idx     = idx_q;
  assign irq        = (st == S_DONE) && is_last && (g_irq || d_irq_q);

  always_comb begin
    case (reg_raddr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = 32'(base_q);
      2'd2:    reg_rdata = 32'({busy, last_q});
      default: reg_rdata = 32'(perf_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl_q  <= '0;
      base_q  <= '0;
      daddr_q <= '0;
      idx_q   <= '0;
      last_q  <= '1;
      len_q   <= '0;
      d_wb_q  <= 1'b0;
      d_irq_q <= 1'b0;
      perf_q  <= '0;
    end else begin
      if (reg_wr && idle) begin
        if (reg_waddr == 2'd0) ctrl_q <= reg_wdata;
        if (reg_waddr == 2'd1) base_q <= AW'(reg_wdata) & ~AW'(15);
      end
      if (start) begin
        idx_q  <= '0;
        last_q <= '1;
        perf_q <= '0;
      end else if (!idle) begin
        perf_q <= perf_q + PW'(1);
      end
      case (st)
        S_IDLE:  if (start) st <= S_FETCH;
        S_FETCH: st <= S_WAIT;
        S_WAIT:
          if (fetch_vld) begin
            len_q   <= fetch_word0[LW-1:0];
            d_wb_q  <= fetch_word0[LW];
            d_irq_q <= fetch_word0[LW+1];
            daddr_q <= fetch_word1;
            st      <= (fetch_word0[LW-1:0] == '0) ? S_DONE : S_XFER;
          end
        S_XFER:  st <= S_XWAIT;
        S_XWAIT: if (xfer_done) st <= S_DONE;
        S_DONE: begin
          last_q <= idx_q;
          if (is_last) st <= S_IDLE;
          else begin
            idx_q <= idx_q + CW'(1);
            st    <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_waddr,
  input logic          busy,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_addr,
  input logic          xfer_req,
  input logic [LW-1:0] xfer_len,
  input logic          wb_req,
  input logic          irq,
  input logic [PW-1:0] perf_q
);
  p_start_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_waddr == 2'd0)) else $error("R2 start without write");

  p_fetch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req) else $error("R3 fetch held");

  p_fetch_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_addr[3:0] == 4'd0) else $error("R3 fetch misaligned");

  p_no_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_len != '0) else $error("R5 zero-length transfer");

  p_wb_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy) else $error("R6 write-back while idle");

  p_one_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fetch_req, xfer_req, wb_req || irq}) <= 1) else $error("R3 overlapping requests");

  p_irq_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !busy) else $error("R8 irq not at end");

  p_perf_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> perf_q == $past(perf_q) + PW'(1)) else $error("R9 counter step");
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW), .LW(LW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .busy(busy),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .xfer_req(xfer_req), .xfer_len(xfer_len),
  .wb_req(wb_req), .irq(irq), .perf_q(perf_q)
);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fetch_req, fetch_vld = 0, xfer_req, xfer_done = 0, wb_req, irq, busy;
  logic [31:0] fetch_addr, fetch_word1 = 0, xfer_addr;
  logic [17:0] fetch_word0 = 0;
  logic [15:0] xfer_len, wb_idx;

  dma_chain_seq uut (.*);

  always #4 clk = ~clk;

  int checks = 0, bad = 0;
  logic [15:0] dlen [8];
  logic        dwb [8], dirq [8];
  int exp_wb [8];
  int exp_nwb, wbp;
  logic [31:0] base_e;
  int lat = 1;
  int nf, nx, nwb, nirq, bcyc;
  int fcnt = 0, xcnt = 0, fi = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      fetch_vld = 0;
      xfer_done = 0;
      if (fcnt > 0) begin
        fcnt--;
        if (fcnt == 0) begin
          fetch_vld = 1;
          fetch_word0 = {dirq[fi], dwb[fi], dlen[fi]};
          fetch_word1 = 32'h4000_0000 + 32'(fi * 256);
        end
      end
      if (xcnt > 0) begin
        xcnt--;
        if (xcnt == 0) xfer_done = 1;
      end
      if (fetch_req) begin
        chk(fetch_addr == base_e + 32'(16 * nf), "R3 fetch address", fetch_addr, base_e + 32'(16 * nf));
        fi = nf & 7;
        nf++;
        fcnt = lat;
      end
      if (xfer_req) begin
        chk(xfer_len == dlen[fi], "R4 transfer length", xfer_len, dlen[fi]);
        chk(xfer_addr == 32'h4000_0000 + 32'(fi * 256), "R4 transfer address", xfer_addr,
            32'h4000_0000 + 32'(fi * 256));
        nx++;
        xcnt = lat;
      end
      if (wb_req) begin
        chk(wbp < exp_nwb && int'(wb_idx) == exp_wb[wbp & 7], "R6 write-back index", wb_idx, exp_wb[wbp & 7]);
        wbp++;
        nwb++;
      end
      if (irq) nirq++;
      if (busy) bcyc++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input int n, input int m, input logic [31:0] base_w, input bit inj);
    logic [31:0] ctrl, r;
    int nzero, exp_irq, it;
    ctrl = {13'b0, m[2], m[1], m[0], 16'(n)};
    base_e = base_w & ~32'hF;
    nzero = 0;
    exp_nwb = 0;
    for (int i = 0; i < n; i++) begin
      if (dlen[i] != 0) nzero++;
      if ((m[1] || dwb[i]) && (m[2] || i == 0 || i == n - 1)) begin
        exp_wb[exp_nwb] = i;
        exp_nwb++;
      end
    end
    exp_irq = (m[0] || dirq[n-1]) ? 1 : 0;
    nf = 0; nx = 0; nwb = 0; nirq = 0; bcyc = 0; wbp = 0;
    lat = 1 + ((n + m) % 3);
    wr(2'd1, base_w);
    reg_wr = 1; reg_waddr = 2'd0; reg_wdata = ctrl;
    @(negedge clk);
    reg_wr = 0;
    chk(busy == 1'b1, "R2 start sets busy", busy, 1);
    it = 0;
    while (busy && it < 2000) begin
      if (inj && it == 2) begin
        rd(2'd2, r);
        chk(r[16] == 1'b1, "R7 busy bit in status", r[16], 1);
      end
      if (inj && it == 3) begin reg_wr = 1; reg_waddr = 2'd0; reg_wdata = 32'h0007_0007; end
      if (inj && it == 4) begin reg_wr = 1; reg_waddr = 2'd1; reg_wdata = 32'h7777_0000; end
      if (inj && it == 5) reg_wr = 0;
      @(negedge clk);
      it++;
    end
    reg_wr = 0;
    chk(it < 2000, "R3 run ends", it, 0);
    chk(nf == n, "R3 fetch count", nf, n);
    chk(nx == nzero, "R5 transfer count", nx, nzero);
    chk(nwb == exp_nwb, "R6 write-back count", nwb, exp_nwb);
    chk(nirq == exp_irq, "R8 irq count", nirq, exp_irq);
    rd(2'd2, r);
    chk(r == 32'(n - 1), "R7 status last index", r, n - 1);
    rd(2'd3, r);
    chk(r == 32'(bcyc), "R9 performance count", r, bcyc);
    if (inj) begin
      rd(2'd0, r);
      chk(r == ctrl, "R10 control unchanged", r, ctrl);
      rd(2'd1, r);
      chk(r == base_e, "R10 base unchanged", r, base_e);
    end
    repeat (3) @(negedge clk);
    rd(2'd3, r);
    chk(r == 32'(bcyc), "R9 counter holds", r, bcyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 8; i++) begin dlen[i] = 0; dwb[i] = 0; dirq[i] = 0; end
    base_e = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(!fetch_req && !xfer_req && !wb_req && !irq, "R1 requests idle", {fetch_req, xfer_req, wb_req, irq}, 0);
    rd(2'd2, r);
    chk(r == 32'h0000_FFFF, "R1 status after reset", r, 32'h0000_FFFF);
    rd(2'd3, r);
    chk(r == 0, "R1 counter after reset", r, 0);

    wr(2'd0, 32'h0007_0000);
    chk(busy == 1'b0, "R2 zero count stays idle", busy, 0);
    nf = 0;
    repeat (4) @(negedge clk);
    chk(nf == 0 && busy == 1'b0, "R2 zero count no fetch", nf, 0);

    for (int n = 1; n <= 5; n++) begin
      for (int m = 0; m < 8; m++) begin
        for (int i = 0; i < 8; i++) begin
          dlen[i] = ((i + n + m) % 4 == 0) ? 16'd0 : 16'(i * 5 + m + 1);
          dwb[i]  = ((i + m) % 3 == 0);
          dirq[i] = ((i + n) % 2 == 1);
        end
        run(n, m, 32'h2000_0000 + 32'(n * m * 64) + 32'h7, 1'b0);
      end
    end

    for (int i = 0; i < 8; i++) begin dlen[i] = 16'(i + 2); dwb[i] = 0; dirq[i] = 0; end
    run(3, 2, 32'h3000_0100, 1'b1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule